// File: doc/BRIEF.md
# Peripheral-to-Pin Priority Crossbar

This block connects a fixed set of on-chip peripheral signals to a bank of general-purpose pins, organised as eight-pin ports. Software enables whole peripheral functions, a count of capture/compare channels, and individual timer and interrupt inputs. The crossbar then packs every enabled signal onto consecutive pins, starting at pin 0 and following a fixed peripheral priority. Any mix of functions can be active at once. Pins that no peripheral claims behave as plain outputs driven from a per-port latch.

Each pin has an output stage. A per-pin mode bit selects push-pull or open-drain drive. A single global bit turns off the weak pullups on every pin. Pins that carry a peripheral input are never driven. Each pin's input value goes back to the peripheral signal placed on it. A peripheral input that has no pin reads 1. If the enabled signals need more pins than the bank has, the signals that do not fit are dropped and an overflow flag is raised.

Configuration is written through a synchronous address/data port. The new pin map is visible right after the clock edge that captures the write.

Top module: `pin_xbar`

## Requirements
- R1: After reset, every pin is open-drain, no peripheral signal is enabled, all port latches are 0xFF, pullups are on, the clock divider selects /1, every peripheral input reads 1 and the overflow flag is 0.
- R2: Enabled signals fill pins from pin 0 upward with no gaps, in this fixed signal order:
  - UART0 tx, rx
  - SPI sck, miso, mosi, nss
  - SMBus sda, scl
  - UART1 tx, rx
  - capture/compare channels 0..6
  - comparator outputs 0, 1
  - T0, T1, T2, T2EX, T4, T4EX, INT0, INT1
  - divided clock output
  - conversion-start input

  These are signal indices 0..28 of the peripheral vectors.
- R3: An enabled signal whose packed position is at or beyond the number of pins gets no pin, and `ovf_o` is then 1. `ovf_o` is 0 whenever all enabled signals fit.
- R4: A pin with no signal on it drives the value of its port latch bit.
- R5: A driving pin in push-pull mode has its output enable at 1. A driving pin in open-drain mode has its output enable at 1 only when the driven value is 0.
- R6: A pin that carries an input-only signal has its output enable at 0 and `pad_o` at 1. The input-only signals are indices 1, 3, 9, 19..26 and 28.
- R7: Each signal that has a pin reads that pin's `pad_i` on `periph_di_o`. Each signal without a pin reads 1.
- R8: `pad_pu_o` is 1 unless the global pullup disable is set or the pin is actively driving 0.
- R9: The 3-bit capture/compare count N (address 1, bits 2:0) enables channels 0..N-1.
- R10: Address 2 enables the eight timer/interrupt signals one by one, with bit 0 for T0 through bit 7 for INT1.
- R11: The clock output runs at the system clock divided by 1, 2, 4 or 8, chosen by address 1 bits 5:4 (values 0..3).
- R12: A write is applied at the clock edge that captures it. The address map is:
  - address 0: group enables. Bit 0 UART0, bit 1 SPI, bit 2 SMBus, bit 3 UART1, bit 4 comparators, bit 5 clock output, bit 6 conversion start.
  - address 1: bit 7 is the global pullup disable.
  - addresses 4+p: latch of port p.
  - addresses 8+p: mode of port p (1 = push-pull).

  Writes to any other address, or with `wr_en_i` low, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | ADDR_W | Configuration register address |
| wr_data_i | input | 8 | Configuration write data |
| periph_do_i | input | 29 | Output values from peripherals, by signal index (bit 27 ignored) |
| periph_di_o | output | 29 | Pin values routed back to peripherals, by signal index |
| pad_i | input | NPORTS*8 | Pin input levels |
| pad_o | output | NPORTS*8 | Pin output values |
| pad_oe_o | output | NPORTS*8 | Pin output enables |
| pad_pu_o | output | NPORTS*8 | Pin weak-pullup enables |
| ovf_o | output | 1 | Enabled signals exceed available pins |

## Verification
The assertions assume that reset is asserted from time zero. They also assume that a write holds address and data stable across the capturing edge, so the write check can compare against the sampled data. They treat `pad_i` as a known level, because the unassigned-input and pullup properties compare whole vectors bit by bit. The stimulus changes every input only on falling edges, holds reset through the first rising edges, and drives `pad_i` with defined values throughout. A second instance with three ports shares the write bus, so the overflow case is reached with the same register writes.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;
  localparam int NSIG  = 29;
  localparam int NPCA  = 7;
  localparam int NTMR  = 8;
  // signal indices, in allocation priority order
  localparam int S_U0  = 0;
  localparam int S_SPI = 2;
  localparam int S_SMB = 6;
  localparam int S_U1  = 8;
  localparam int S_PCA = 10;
  localparam int S_CMP = 17;
  localparam int S_TMR = 19;
  localparam int S_CLK = 27;
  localparam int S_CNV = 28;
  // 1 = signal drives its pin, 0 = input only
  localparam logic [NSIG-1:0] SIG_OUT = 29'h807_FDF5;
  // group enable bits at address 0
  localparam int G_U0  = 0;
  localparam int G_SPI = 1;
  localparam int G_SMB = 2;
  localparam int G_U1  = 3;
  localparam int G_CMP = 4;
  localparam int G_CLK = 5;
  localparam int G_CNV = 6;
  // register addresses
  localparam int A_GRP   = 0;
  localparam int A_MISC  = 1;
  localparam int A_TMR   = 2;
  localparam int A_LATCH = 4;
  localparam int A_MODE  = 8;

  typedef struct packed {
    logic [6:0] grp_en;
    logic [2:0] pca_cnt;
    logic [1:0] clk_sel;
    logic       pu_dis;
    logic [7:0] tmr_en;
  } xbar_cfg_t;
endpackage

// File: rtl/pin_xbar_regs.sv
module pin_xbar_regs
  import pin_xbar_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int ADDR_W = 4,
  localparam int NPINS = NPORTS * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output xbar_cfg_t         cfg_o,
  output logic [NPINS-1:0]  latch_o,
  output logic [NPINS-1:0]  pp_o
);
  logic [7:0] lat_q [NPORTS];
  logic [7:0] pp_q  [NPORTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
      for (int p = 0; p < NPORTS; p++) begin
        lat_q[p] <= 8'hFF;
        pp_q[p]  <= 8'h00;
      end
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(A_GRP)) cfg_o.grp_en <= wr_data_i[6:0];
      if (wr_addr_i == ADDR_W'(A_MISC)) begin
        cfg_o.pca_cnt <= wr_data_i[2:0];
        cfg_o.clk_sel <= wr_data_i[5:4];
        cfg_o.pu_dis  <= wr_data_i[7];
      end
      if (wr_addr_i == ADDR_W'(A_TMR)) cfg_o.tmr_en <= wr_data_i;
      for (int p = 0; p < NPORTS; p++) begin
        if (wr_addr_i == ADDR_W'(A_LATCH + p)) lat_q[p] <= wr_data_i;
        if (wr_addr_i == ADDR_W'(A_MODE + p))  pp_q[p]  <= wr_data_i;
      end
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign latch_o[p*8 +: 8] = lat_q[p];
    assign pp_o[p*8 +: 8]    = pp_q[p];
  end
endmodule

// File: rtl/pin_xbar_alloc.sv
module pin_xbar_alloc #(
  parameter int NSIG  = 29,
  parameter int NPINS = 32,
  localparam int IDX_W = $clog2(NSIG),
  localparam int PW    = $clog2(NSIG + 1)
) (
  input  logic [NSIG-1:0]  sig_en_i,
  output logic [NSIG-1:0]  sig_vld_o,
  output logic [PW-1:0]    sig_pos_o [NSIG],
  output logic [NPINS-1:0] pin_vld_o,
  output logic [IDX_W-1:0] pin_idx_o [NPINS],
  output logic             ovf_o
);
  // running count of enabled signals ahead of each index
  logic [PW-1:0] run [NSIG];
  assign run[0] = '0;
  for (genvar s = 1; s < NSIG; s++) begin : g_pfx
    assign run[s] = run[s-1] + PW'(sig_en_i[s-1]);
  end

  for (genvar s = 0; s < NSIG; s++) begin : g_sig
    assign sig_pos_o[s] = run[s];
    assign sig_vld_o[s] = sig_en_i[s] && (32'(run[s]) < NPINS);
  end

  assign ovf_o = |(sig_en_i & ~sig_vld_o);

  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      pin_vld_o[p] = 1'b0;
      pin_idx_o[p] = '0;
      for (int s = 0; s < NSIG; s++) begin
        if (sig_vld_o[s] && 32'(sig_pos_o[s]) == p) begin
          pin_vld_o[p] = 1'b1;
          pin_idx_o[p] = IDX_W'(s);
        end
      end
    end
  end
endmodule

// File: rtl/pin_xbar_clkdiv.sv
module pin_xbar_clkdiv (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  output logic       clk_o
);
  logic [2:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 3'd1;
  end

  always_comb begin
    case (sel_i)
      2'd0:    clk_o = clk_i;
      2'd1:    clk_o = cnt_q[0];
      2'd2:    clk_o = cnt_q[1];
      default: clk_o = cnt_q[2];
    endcase
  end
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pin_xbar_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int ADDR_W = 4,
  localparam int NPINS = NPORTS * 8,
  localparam int IDX_W = $clog2(NSIG),
  localparam int PW    = $clog2(NSIG + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [NSIG-1:0]   periph_do_i,
  output logic [NSIG-1:0]   periph_di_o,
  input  logic [NPINS-1:0]  pad_i,
  output logic [NPINS-1:0]  pad_o,
  output logic [NPINS-1:0]  pad_oe_o,
  output logic [NPINS-1:0]  pad_pu_o,
  output logic              ovf_o
);
  xbar_cfg_t        cfg;
  logic [NPINS-1:0] latch, pp;
  logic [NSIG-1:0]  sig_en, sig_vld, sig_do;
  logic [PW-1:0]    sig_pos [NSIG];
  logic [NPINS-1:0] pin_vld;
  logic [IDX_W-1:0] pin_idx [NPINS];
  logic             clk_div;

  pin_xbar_regs #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .cfg_o(cfg), .latch_o(latch), .pp_o(pp)
  );

  pin_xbar_clkdiv u_div (
    .clk_i, .rst_ni, .sel_i(cfg.clk_sel), .clk_o(clk_div)
  );

  always_comb begin
    sig_en = '0;
    sig_en[S_U0  +: 2] = {2{cfg.grp_en[G_U0]}};
    sig_en[S_SPI +: 4] = {4{cfg.grp_en[G_SPI]}};
    sig_en[S_SMB +: 2] = {2{cfg.grp_en[G_SMB]}};
    sig_en[S_U1  +: 2] = {2{cfg.grp_en[G_U1]}};
    for (int k = 0; k < NPCA; k++) sig_en[S_PCA + k] = (32'(cfg.pca_cnt) > k);
    sig_en[S_CMP +: 2]    = {2{cfg.grp_en[G_CMP]}};
    sig_en[S_TMR +: NTMR] = cfg.tmr_en;
    sig_en[S_CLK]         = cfg.grp_en[G_CLK];
    sig_en[S_CNV]         = cfg.grp_en[G_CNV];
  end

  pin_xbar_alloc #(.NSIG(NSIG), .NPINS(NPINS)) u_alloc (
    .sig_en_i(sig_en), .sig_vld_o(sig_vld), .sig_pos_o(sig_pos),
    .pin_vld_o(pin_vld), .pin_idx_o(pin_idx), .ovf_o(ovf_o)
  );

  // clock-out slot is sourced internally
  assign sig_do = (periph_do_i & ~(NSIG'(1) << S_CLK)) | (NSIG'(clk_div) << S_CLK);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic drv, dat;
    assign drv         = pin_vld[p] ? SIG_OUT[pin_idx[p]] : 1'b1;
    assign dat         = pin_vld[p] ? sig_do[pin_idx[p]] : latch[p];
    assign pad_oe_o[p] = drv & (pp[p] | ~dat);
    assign pad_o[p]    = drv ? dat : 1'b1;
    assign pad_pu_o[p] = ~cfg.pu_dis & ~(pad_oe_o[p] & ~pad_o[p]);
  end

  always_comb begin
    periph_di_o = '1;
    for (int s = 0; s < NSIG; s++) begin
      for (int p = 0; p < NPINS; p++) begin
        if (sig_vld[s] && 32'(sig_pos[s]) == p) periph_di_o[s] = pad_i[p];
      end
    end
  end
endmodule

// File: rtl/pin_xbar_chk.sv
module pin_xbar_chk
  import pin_xbar_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int ADDR_W = 4,
  localparam int NPINS = NPORTS * 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [7:0]        wr_data_i,
  input logic [NSIG-1:0]   periph_di_o,
  input logic [NPINS-1:0]  pad_o,
  input logic [NPINS-1:0]  pad_oe_o,
  input logic [NPINS-1:0]  pad_pu_o,
  input logic              ovf_o,
  input xbar_cfg_t         cfg,
  input logic [NPINS-1:0]  pp,
  input logic [NSIG-1:0]   sig_en,
  input logic [NSIG-1:0]   sig_vld,
  input logic              clk_div
);
  p_ovf_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o == ($countones(sig_en) > NPINS));

  p_od_never_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & pad_o & ~pp) == '0);

  p_unassigned_one_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~sig_vld & ~periph_di_o) == '0);

  p_pu_global_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.pu_dis |-> pad_pu_o == '0);

  p_pu_low_drive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~pad_o & pad_pu_o) == '0);

  p_div2_toggle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.clk_sel == 2'd1 && $past(cfg.clk_sel) == 2'd1) |-> clk_div != $past(clk_div));

  p_grp_write_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_W'(A_GRP)) |=> cfg.grp_en == $past(wr_data_i[6:0]));
endmodule

bind pin_xbar pin_xbar_chk #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .periph_di_o(periph_di_o), .pad_o(pad_o),
  .pad_oe_o(pad_oe_o), .pad_pu_o(pad_pu_o), .ovf_o(ovf_o), .cfg(cfg),
  .pp(pp), .sig_en(sig_en), .sig_vld(sig_vld), .clk_div(clk_div)
);

// File: tb/sim_pin_xbar.sv
module sim_pin_xbar;
  import pin_xbar_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic            wr_en = 1'b0;
  logic [3:0]      wr_addr = '0;
  logic [7:0]      wr_data = '0;
  logic [NSIG-1:0] pdo = '0;
  logic [31:0]     pad_in = '1;

  logic [NSIG-1:0] di0, di1;
  logic [31:0]     po0, oe0, pu0;
  logic [23:0]     po1, oe1, pu1;
  logic            ovf0, ovf1;

  pin_xbar #(.NPORTS(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .periph_do_i(pdo), .periph_di_o(di0), .pad_i(pad_in),
    .pad_o(po0), .pad_oe_o(oe0), .pad_pu_o(pu0), .ovf_o(ovf0)
  );

  pin_xbar #(.NPORTS(3)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .periph_do_i(pdo), .periph_di_o(di1), .pad_i(pad_in[23:0]),
    .pad_o(po1), .pad_oe_o(oe1), .pad_pu_o(pu1), .ovf_o(ovf1)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    pad_in = '0; #1;
    chk("R1 pad_o", po0, 32'hFFFF_FFFF);
    chk("R1 pad_oe", oe0, 32'h0);
    chk("R1 pad_pu", pu0, 32'hFFFF_FFFF);
    chk("R1 periph_di", di0, 29'h1FFF_FFFF);
    chk("R1 ovf", ovf0, 0);
  endtask

  task automatic t_pack();
    do_reset();
    pdo = 29'h0002_0040; pad_in = 32'hFFFF_FFFD;
    wr(4'd8, 8'hFF);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = 8'h15;
    #5;
    chk("R12 before edge", oe0[7:0], 8'hFF);
    @(negedge clk);
    wr_en = 1'b0; #1;
    chk("R12 after edge", oe0[7:0], 8'hFD);
    chk("R2 pack pad_o", po0[7:0], 8'hD6);
    chk("R6 input pin idle", {oe0[1], po0[1]}, 2'b01);
    chk("R7 routing", di0, 29'h1FFF_FFFD);
    chk("R4 latch pins", po0[15:8], 8'hFF);
  endtask

  task automatic t_pca();
    do_reset();
    pdo = 29'h0000_1824;
    wr(4'd8, 8'hFF);
    wr(4'd0, 8'h02);
    wr(4'd1, 8'h03);
    chk("R9 pca pad_o", po0[7:0], 8'hEB);
    chk("R9 pca pad_oe", oe0[7:0], 8'hFD);
    chk("R4 next port latch", {oe0[8], po0[8]}, 2'b01);
  endtask

  task automatic t_tmr();
    do_reset();
    wr(4'd2, 8'h41);
    pad_in = 32'hFFFF_FFFD; #1;
    chk("R10 tmr oe", oe0[1:0], 2'b00);
    chk("R10 tmr routing", di0[26:19], 8'hBF);
    pad_in = 32'hFFFF_FFFE; #1;
    chk("R7 t0 reroute", {di0[25], di0[19]}, 2'b10);
    wr(4'd4, 8'h00);
    chk("R5 od low drive oe", oe0[7:0], 8'hFC);
    chk("R4 latch low", po0[7:0], 8'h03);
    chk("R8 pu off when low", pu0[7:0], 8'h03);
  endtask

  task automatic t_all();
    do_reset();
    pdo = 29'h0001_0000; pad_in = 32'hEFFF_FFFF;
    wr(4'd11, 8'hFF);
    wr(4'd0, 8'h7F);
    wr(4'd1, 8'h07);
    wr(4'd2, 8'hFF);
    chk("R3 all fit ovf", ovf0, 0);
    chk("R2 tail oe", oe0[31:28], 4'b1110);
    chk("R6 inputs undriven", oe0[26:19], 8'h00);
    chk("R2 pca6 pin", {po0[16], po0[15]}, 2'b10);
    chk("R7 cnv pin", di0[28], 0);
    pad_in = '0; #1;
    chk("R3 ovf small bank", ovf1, 1);
    chk("R3 dropped read 1", {di1[28:24], di1[23]}, 6'b111110);
    wr(4'd2, 8'h00);
    chk("R3 ovf clears", ovf1, 0);
    chk("R2 repack cnv", di1[28], 0);
  endtask

  task automatic t_mode_pu();
    do_reset();
    wr(4'd5, 8'hA5);
    wr(4'd9, 8'h0F);
    chk("R5 mode oe", oe0[15:8], 8'h5F);
    chk("R4 latch value", po0[15:8], 8'hA5);
    chk("R8 pu pattern", pu0[15:8], 8'hA5);
    wr(4'd1, 8'h80);
    chk("R8 global off", pu0, 32'h0);
  endtask

  task automatic t_ignore();
    logic [31:0] s_po, s_oe, s_pu;
    logic [NSIG-1:0] s_di;
    s_po = po0; s_oe = oe0; s_pu = pu0; s_di = di0;
    wr(4'd3, 8'hFF);
    wr(4'd12, 8'h00);
    wr(4'd15, 8'h00);
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 4'd5; wr_data = 8'h00;
    @(negedge clk); #1;
    chk("R12 ignored writes", {s_po, s_oe}, {po0, oe0});
    chk("R12 ignored pu/di", {s_pu, 3'b0, s_di}, {pu0, 3'b0, di0});
  endtask

  task automatic t_clk();
    logic s [8];
    int errs;
    do_reset();
    wr(4'd8, 8'h01);
    wr(4'd0, 8'h20);
    @(posedge clk); #1;
    chk("R11 div1 high", po0[0], 1);
    @(negedge clk); #1;
    chk("R11 div1 low", po0[0], 0);
    for (int sel = 1; sel < 4; sel++) begin
      wr(4'd1, 8'(sel << 4));
      for (int i = 0; i < 8; i++) begin
        @(negedge clk); #1;
        s[i] = po0[0];
      end
      errs = 0;
      for (int i = 0; i < 8; i++) begin
        if (i >= (1 << (sel - 1)) && s[i] == s[i - (1 << (sel - 1))]) errs++;
      end
      chk($sformatf("R11 div sel %0d", sel), errs, 0);
    end
  endtask

  initial begin
    #(20 * 100000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_pack();
    t_pca();
    t_tmr();
    t_all();
    t_mode_pu();
    t_ignore();
    t_clk();
    finish_run();
  end
endmodule